// File: doc/BRIEF.md
# Per-Core Vectored Interrupt Sequencer

This block runs interrupt entry and return for one processor core. External sources raise any of 32 trigger lines, and each trigger sets one bit of a pending register. A source that raises a line which is already pending gets a duplicate indication in the same cycle. The core owns a table of 32 handler addresses and writes it through a simple write port. Software can also drop pending bits with a write-one-to-clear mask.

When the core reports an instruction boundary and the interrupt-enable bit of its status word is set, the sequencer maps the lowest-numbered pending interrupt and consumes its pending bit. An entry whose handler address is zero is skipped at the cost of one cycle, and the scan then repeats. For a real handler it pushes the status word and then the program counter through a stack-write port. It then hands the core a new program counter, the status word with enable cleared, and the lowered stack pointer. A return request pops both words back in the opposite order. `busy_o` is high while any of this runs, and the core holds instruction issue while it is high.

Top module: `core_irq_sequencer`

## Requirements
- R1: After reset `pend_o` is all zero, `busy_o` is low, `trig_dup_o` is zero and every handler address reads as zero.
- R2: A pulse on `trig_i[k]` sets `pend_o[k]` from the next cycle. `trig_dup_o[k]` stays low when bit k was not pending.
- R3: A pulse on `trig_i[k]` while `pend_o[k]` is set, and not being cleared in that cycle, raises `trig_dup_o[k]` in the same cycle and leaves the pending register unchanged.
- R4: A one in `pend_clr_i[k]` clears `pend_o[k]` from the next cycle. If `trig_i[k]` is high in the same cycle, the trigger wins: the bit stays set and no duplicate is reported.
- R5: A sequence starts only when the sequencer is idle, `boundary_i` is high, `st_i` bit 4 (interrupt enable) is set and at least one bit is pending. Otherwise `busy_o` stays low.
- R6: Each mapping cycle selects the lowest-numbered pending bit and clears it.
- R7: A selected entry with handler address zero causes no stack activity and takes exactly one cycle. Mapping repeats if other bits are still pending, and the sequencer goes idle if none are.
- R8: A valid handler is entered in 3 cycles after its mapping cycle. The first cycle writes ST to SP-1, the second writes PC to SP-2, and the third asserts `ctx_load_o` with PC = handler address, ST with bit 4 cleared and SP = SP-2. A direct entry therefore keeps `busy_o` high for 4 cycles. Addresses wrap modulo 2^16.
- R9: `reti_i` while idle runs a 3-cycle return. PC is read at SP, ST is read at SP+1, and then `ctx_load_o` delivers both with SP+2. `reti_i` takes priority over `boundary_i` in the same cycle, and that boundary is ignored.
- R10: A write with `vec_we_i` stores `vec_addr_i` at entry `vec_idx_i`. Every mapping that starts in a later cycle uses the stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 32 | Per-line trigger pulses |
| trig_dup_o | output | 32 | Same-cycle duplicate indication per line |
| pend_clr_i | input | 32 | Write-one-to-clear mask for pending bits |
| pend_o | output | 32 | Pending register |
| vec_we_i | input | 1 | Handler table write strobe |
| vec_idx_i | input | 5 | Handler table entry index |
| vec_addr_i | input | 16 | Handler address to store |
| boundary_i | input | 1 | Core finished an instruction |
| reti_i | input | 1 | Return-from-interrupt request |
| pc_i | input | 16 | Current program counter |
| st_i | input | 16 | Current status word (bit 4 = interrupt enable) |
| sp_i | input | 16 | Current stack pointer (points at last pushed word) |
| busy_o | output | 1 | Sequence running; core stalls issue |
| stk_we_o | output | 1 | Stack write strobe |
| stk_addr_o | output | 16 | Stack word address for read or write |
| stk_wdata_o | output | 16 | Stack write data |
| stk_rdata_i | input | 16 | Stack read data for `stk_addr_o`, same cycle |
| ctx_load_o | output | 1 | Core loads PC, ST and SP from the next three ports |
| pc_new_o | output | 16 | Program counter to load |
| st_new_o | output | 16 | Status word to load |
| sp_new_o | output | 16 | Stack pointer to load |

## Verification
The assertions assume that the core raises `boundary_i` and `reti_i` only while `busy_o` is low, that it applies `ctx_load_o` in the cycle it is shown, and that the stack returns the word at `stk_addr_o` combinationally. The stimulus follows these rules. It waits for `busy_o` to fall before each new request, models the core registers and a stack memory that obey the load and write strobes, and issues `reti_i` only after a matching entry. Inputs change shortly after the rising edge and are held for a full cycle, so pending-bit races are provoked only on purpose. This is done by pairing a trigger with a clear on the same line.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MAP  = 3'd1,
    S_ENT1 = 3'd2,
    S_ENT2 = 3'd3,
    S_ENT3 = 3'd4,
    S_EXT1 = 3'd5,
    S_EXT2 = 3'd6,
    S_EXT3 = 3'd7
  } seq_state_e;
endpackage

// File: rtl/irq_pending.sv
`timescale 1ns/1ps
module irq_pending #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] dup_o
);
  logic [N-1:0] pend_q, pend_d, wipe;
  logic         pend_en;

  always_comb begin
    wipe    = clr_i | take_i;
    pend_d  = (pend_q & ~wipe) | trig_i;   // trigger beats any clear
    pend_en = (|trig_i) | (|wipe);
    dup_o   = trig_i & pend_q & ~wipe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  p_trig_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_i) |=> ((pend_o & $past(trig_i)) == $past(trig_i)));

  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~trig_i)) |=> ((pend_o & $past(clr_i & ~trig_i)) == '0));

  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(trig_i)) == '0));
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    any_o    = |req_i;
    onehot_o = req_i & (~req_i + N'(1));
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    p_pick_lowest_r6: assert (!any_o ||
      ($onehot(onehot_o) && req_i[idx_o] && ((req_i & (onehot_o - N'(1))) == '0)));
  end
endmodule

// File: rtl/irq_vec_table.sv
`timescale 1ns/1ps
module irq_vec_table #(
  parameter int N = 32,
  parameter int W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] ent_w [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic         ent_en;
    logic [W-1:0] ent_q;
    assign ent_en = we_i && (widx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= wdata_i;
    end
    assign ent_w[g] = ent_q;
  end

  assign rdata_o = ent_w[ridx_i];

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ent_w[$past(widx_i)] == $past(wdata_i)));
endmodule

// File: rtl/core_irq_sequencer.sv
`timescale 1ns/1ps
module core_irq_sequencer
  import irq_seq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int WORD_W    = 16,
  parameter int IE_BIT    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] trig_i,
  output logic [NUM_LINES-1:0] trig_dup_o,
  input  logic [NUM_LINES-1:0] pend_clr_i,
  output logic [NUM_LINES-1:0] pend_o,
  input  logic                 vec_we_i,
  input  logic [IDX_W-1:0]     vec_idx_i,
  input  logic [WORD_W-1:0]    vec_addr_i,
  input  logic                 boundary_i,
  input  logic                 reti_i,
  input  logic [WORD_W-1:0]    pc_i,
  input  logic [WORD_W-1:0]    st_i,
  input  logic [WORD_W-1:0]    sp_i,
  output logic                 busy_o,
  output logic                 stk_we_o,
  output logic [WORD_W-1:0]    stk_addr_o,
  output logic [WORD_W-1:0]    stk_wdata_o,
  input  logic [WORD_W-1:0]    stk_rdata_i,
  output logic                 ctx_load_o,
  output logic [WORD_W-1:0]    pc_new_o,
  output logic [WORD_W-1:0]    st_new_o,
  output logic [WORD_W-1:0]    sp_new_o
);
  localparam logic [WORD_W-1:0] IE_MASK = WORD_W'(1) << IE_BIT;

  seq_state_e state_q, state_d;
  logic [WORD_W-1:0] sp_q, sp_d, pc_q, pc_d, st_q, st_d, vec_q;
  logic sp_en, pc_en, st_en, vec_en;
  logic pick_any, in_map, start_irq, start_ret, rescan, vec_zero;
  logic [IDX_W-1:0]     pick_idx;
  logic [NUM_LINES-1:0] pick_oh, take_oh;
  logic [WORD_W-1:0]    vec_rd;

  irq_pending #(.N(NUM_LINES)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .clr_i  (pend_clr_i),
    .take_i (take_oh),
    .pend_o (pend_o),
    .dup_o  (trig_dup_o)
  );

  irq_pick #(.N(NUM_LINES)) u_pick (
    .req_i    (pend_o),
    .any_o    (pick_any),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  irq_vec_table #(.N(NUM_LINES), .W(WORD_W)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (vec_we_i),
    .widx_i  (vec_idx_i),
    .wdata_i (vec_addr_i),
    .ridx_i  (pick_idx),
    .rdata_o (vec_rd)
  );

  // next-state logic
  always_comb begin
    start_ret = (state_q == S_IDLE) && reti_i;
    start_irq = (state_q == S_IDLE) && !reti_i && boundary_i && st_i[IE_BIT] && pick_any;
    in_map    = (state_q == S_MAP);
    vec_zero  = (vec_rd == '0);
    take_oh   = (in_map && pick_any) ? pick_oh : '0;
    rescan    = |(pend_o & ~pick_oh);
    state_d   = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_ret)      state_d = S_EXT1;
        else if (start_irq) state_d = S_MAP;
      end
      S_MAP: begin
        if (!pick_any)     state_d = S_IDLE;
        else if (!vec_zero) state_d = S_ENT1;
        else if (rescan)   state_d = S_MAP;
        else               state_d = S_IDLE;
      end
      S_ENT1:  state_d = S_ENT2;
      S_ENT2:  state_d = S_ENT3;
      S_ENT3:  state_d = S_IDLE;
      S_EXT1:  state_d = S_EXT2;
      S_EXT2:  state_d = S_EXT3;
      S_EXT3:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // datapath next values and clock enables
  always_comb begin
    sp_d   = sp_q;
    pc_d   = pc_q;
    st_d   = st_q;
    sp_en  = 1'b0;
    pc_en  = 1'b0;
    st_en  = 1'b0;
    vec_en = in_map && pick_any && !vec_zero;
    if (start_irq || start_ret) begin
      pc_d  = pc_i;
      st_d  = st_i;
      sp_d  = sp_i;
      pc_en = 1'b1;
      st_en = 1'b1;
      sp_en = 1'b1;
    end
    unique case (state_q)
      S_ENT1, S_ENT2: begin
        sp_d  = sp_q - WORD_W'(1);
        sp_en = 1'b1;
      end
      S_EXT1: begin
        pc_d  = stk_rdata_i;
        pc_en = 1'b1;
        sp_d  = sp_q + WORD_W'(1);
        sp_en = 1'b1;
      end
      S_EXT2: begin
        st_d  = stk_rdata_i;
        st_en = 1'b1;
        sp_d  = sp_q + WORD_W'(1);
        sp_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sp_q    <= '0;
      pc_q    <= '0;
      st_q    <= '0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (sp_en)  sp_q  <= sp_d;
      if (pc_en)  pc_q  <= pc_d;
      if (st_en)  st_q  <= st_d;
      if (vec_en) vec_q <= vec_rd;
    end
  end

  // outputs
  always_comb begin
    busy_o      = (state_q != S_IDLE);
    stk_we_o    = (state_q == S_ENT1) || (state_q == S_ENT2);
    stk_addr_o  = stk_we_o ? (sp_q - WORD_W'(1)) : sp_q;
    stk_wdata_o = (state_q == S_ENT2) ? pc_q : st_q;
    ctx_load_o  = (state_q == S_ENT3) || (state_q == S_EXT3);
    pc_new_o    = (state_q == S_ENT3) ? vec_q : pc_q;
    st_new_o    = (state_q == S_ENT3) ? (st_q & ~IE_MASK) : st_q;
    sp_new_o    = sp_q;
  end

  p_start_needs_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !reti_i && !(boundary_i && st_i[IE_BIT])) |=> !busy_o);

  p_zero_no_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_MAP && vec_rd == '0) |=> !stk_we_o);

  p_push_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ENT1) |=> (stk_we_o && stk_addr_o == $past(stk_addr_o) - WORD_W'(1)));

  p_entry_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ENT3) |-> (ctx_load_o && !st_new_o[IE_BIT] && pc_new_o != '0));

  p_exit_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_EXT3) |-> (ctx_load_o && sp_new_o == $past(stk_addr_o) + WORD_W'(1)));
endmodule

// File: tb/sim_core_irq_sequencer.sv
`timescale 1ns/1ps
module sim_core_irq_sequencer;
  localparam int N = 32;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic         rst_n;
  logic [N-1:0] trig, dup, clr, pend;
  logic         vec_we;
  logic [4:0]   vec_idx;
  logic [W-1:0] vec_addr;
  logic         bnd, reti, busy, stk_we, ctx_load;
  logic [W-1:0] stk_addr, stk_wdata, stk_rdata, pc_new, st_new, sp_new;
  logic [W-1:0] core_pc, core_st, core_sp, cfg_pc, cfg_st, cfg_sp;
  logic         cfg_we;
  logic [W-1:0] smem [256];

  core_irq_sequencer #(.NUM_LINES(N), .WORD_W(W), .IE_BIT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .trig_dup_o(dup),
    .pend_clr_i(clr), .pend_o(pend), .vec_we_i(vec_we), .vec_idx_i(vec_idx),
    .vec_addr_i(vec_addr), .boundary_i(bnd), .reti_i(reti),
    .pc_i(core_pc), .st_i(core_st), .sp_i(core_sp), .busy_o(busy),
    .stk_we_o(stk_we), .stk_addr_o(stk_addr), .stk_wdata_o(stk_wdata),
    .stk_rdata_i(stk_rdata), .ctx_load_o(ctx_load), .pc_new_o(pc_new),
    .st_new_o(st_new), .sp_new_o(sp_new)
  );

  // core register model and stack memory
  always @(posedge clk) begin
    if (cfg_we) begin
      core_pc <= cfg_pc; core_st <= cfg_st; core_sp <= cfg_sp;
    end else if (ctx_load) begin
      core_pc <= pc_new; core_st <= st_new; core_sp <= sp_new;
    end
    if (stk_we) smem[stk_addr[7:0]] <= stk_wdata;
  end
  assign stk_rdata = smem[stk_addr[7:0]];

  // scoreboard
  typedef struct packed {
    logic         is_load;
    logic         is_exit;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] c;
  } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (stk_we) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R7/R8 unexpected stack write act %h<-%h exp none", stk_addr, stk_wdata);
        end else begin
          e = exp_q.pop_front();
          if (e.is_load || e.a !== stk_addr || e.b !== stk_wdata) begin
            errors++;
            $display("FAIL R8 stack write act %h<-%h exp %h<-%h", stk_addr, stk_wdata, e.a, e.b);
          end
        end
      end
      if (ctx_load) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8/R9 unexpected load act %h/%h/%h exp none", pc_new, st_new, sp_new);
        end else begin
          e = exp_q.pop_front();
          if (!e.is_load || e.a !== pc_new || e.b !== st_new || e.c !== sp_new) begin
            errors++;
            $display("FAIL %s load pc/st/sp act %h/%h/%h exp %h/%h/%h",
                     e.is_exit ? "R9" : "R8", pc_new, st_new, sp_new, e.a, e.b, e.c);
          end
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic set_core(input logic [W-1:0] p, input logic [W-1:0] s, input logic [W-1:0] sp);
    cyc();
    cfg_pc = p; cfg_st = s; cfg_sp = sp; cfg_we = 1'b1;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic wr_vec(input logic [4:0] idx, input logic [W-1:0] addr);
    cyc();
    vec_we = 1'b1; vec_idx = idx; vec_addr = addr;
    cyc();
    vec_we = 1'b0;
  endtask

  // drive trigger/clear masks for one cycle; report duplicate flags
  task automatic pulse(input logic [N-1:0] t, input logic [N-1:0] c, output logic [N-1:0] d);
    cyc();
    trig = t; clr = c;
    @(negedge clk);
    d = dup;
    cyc();
    trig = '0; clr = '0;
  endtask

  // request boundary and/or return; count busy cycles
  task automatic step(input logic b, input logic r, output int n);
    cyc();
    bnd = b; reti = r;
    cyc();
    bnd = 1'b0; reti = 1'b0;
    n = 0;
    repeat (30) begin
      @(negedge clk);
      if (busy) n++;
      else break;
    end
  endtask

  task automatic exp_entry(input logic [W-1:0] p, input logic [W-1:0] s,
                           input logic [W-1:0] sp, input logic [W-1:0] v);
    logic [W-1:0] s1, s2;
    s1 = sp - 16'd1;
    s2 = sp - 16'd2;
    exp_q.push_back('{1'b0, 1'b0, s1, s, 16'h0});
    exp_q.push_back('{1'b0, 1'b0, s2, p, 16'h0});
    exp_q.push_back('{1'b1, 1'b0, v, s & ~16'h0010, s2});
  endtask

  task automatic exp_exit(input logic [W-1:0] p, input logic [W-1:0] s, input logic [W-1:0] sp);
    exp_q.push_back('{1'b1, 1'b1, p, s, sp});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    int n;
    rst_n = 1'b0; trig = '0; clr = '0; vec_we = 1'b0; vec_idx = '0; vec_addr = '0;
    bnd = 1'b0; reti = 1'b0; cfg_we = 1'b0; cfg_pc = '0; cfg_st = '0; cfg_sp = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 pending after reset", pend, 32'd0);
    chk("R1 dup after reset", dup, 32'd0);

    set_core(16'h0100, 16'h0010, 16'h0000);
    wr_vec(5'd3, 16'h4000);
    wr_vec(5'd7, 16'h7000);
    wr_vec(5'd5, 16'h5000);
    wr_vec(5'd31, 16'h3100);

    // R2: first trigger sets pending, no duplicate
    pulse(32'h8, 32'h0, d);
    chk("R2 dup on fresh trigger", d, 32'h0);
    @(negedge clk);
    chk("R2 pending set", pend, 32'h8);

    // R3: duplicate reported, pending unchanged
    pulse(32'h8, 32'h0, d);
    chk("R3 dup flagged", d, 32'h8);
    @(negedge clk);
    chk("R3 pending unchanged", pend, 32'h8);

    // R4: clear, then trigger beats clear
    pulse(32'h0, 32'h8, d);
    @(negedge clk);
    chk("R4 clear drops bit", pend, 32'h0);
    pulse(32'h0, 32'h0, d);
    pulse(32'h8, 32'h0, d);
    pulse(32'h8, 32'h8, d);
    chk("R4 no dup when clear collides", d, 32'h0);
    @(negedge clk);
    chk("R4 trigger wins over clear", pend, 32'h8);

    // R5: enable clear -> nothing happens
    set_core(16'h0100, 16'h0000, 16'h0000);
    step(1'b1, 1'b0, n);
    chk("R5 no start with enable clear", n, 0);
    chk("R5 pending kept", pend, 32'h8);

    // R6/R8: lowest of bits 3 and 7 taken first
    pulse(32'h80, 32'h0, d);
    set_core(16'h0100, 16'h0013, 16'h0000);
    exp_entry(16'h0100, 16'h0013, 16'h0000, 16'h4000);
    step(1'b1, 1'b0, n);
    chk("R8 entry busy cycles", n, 4);
    chk("R6 lowest bit consumed", pend, 32'h80);
    chk("R8 core pc after entry", core_pc, 16'h4000);
    chk("R8 core st enable cleared", core_st, 16'h0003);

    // R5: inside handler enable is clear
    step(1'b1, 1'b0, n);
    chk("R5 masked inside handler", n, 0);

    // R9: return wins over boundary in same cycle
    exp_exit(16'h0100, 16'h0013, 16'h0000);
    step(1'b1, 1'b1, n);
    chk("R9 return busy cycles", n, 3);
    chk("R9 boundary ignored, pending kept", pend, 32'h80);
    chk("R9 enable restored", core_st, 16'h0013);

    // R6: remaining bit 7
    exp_entry(16'h0100, 16'h0013, 16'h0000, 16'h7000);
    step(1'b1, 1'b0, n);
    chk("R8 entry busy for line 7", n, 4);
    chk("R6 pending empty", pend, 32'h0);
    exp_exit(16'h0100, 16'h0013, 16'h0000);
    step(1'b0, 1'b1, n);
    chk("R9 return busy", n, 3);

    // R7: zero vector on line 2 skipped, line 5 taken
    pulse(32'h24, 32'h0, d);
    exp_entry(16'h0100, 16'h0013, 16'h0000, 16'h5000);
    step(1'b1, 1'b0, n);
    chk("R7 skip adds one cycle", n, 5);
    chk("R7 both bits consumed", pend, 32'h0);
    exp_exit(16'h0100, 16'h0013, 16'h0000);
    step(1'b0, 1'b1, n);

    // R7: zero vector alone -> one cycle, no stack activity
    pulse(32'h4, 32'h0, d);
    step(1'b1, 1'b0, n);
    chk("R7 lone zero vector cycles", n, 1);
    chk("R7 lone zero consumed", pend, 32'h0);
    chk("R7 pc untouched", core_pc, 16'h0100);

    // R10: newly written vector is used
    wr_vec(5'd2, 16'h2200);
    pulse(32'h4, 32'h0, d);
    exp_entry(16'h0100, 16'h0013, 16'h0000, 16'h2200);
    step(1'b1, 1'b0, n);
    chk("R10 entry with written vector", n, 4);
    chk("R10 pc from written vector", core_pc, 16'h2200);
    exp_exit(16'h0100, 16'h0013, 16'h0000);
    step(1'b0, 1'b1, n);

    // R8/R9: stack pointer wrap, top line 31
    set_core(16'h0ABC, 16'h8011, 16'h0001);
    pulse(32'h8000_0000, 32'h0, d);
    exp_entry(16'h0ABC, 16'h8011, 16'h0001, 16'h3100);
    step(1'b1, 1'b0, n);
    chk("R8 wrap entry cycles", n, 4);
    chk("R8 wrapped sp", core_sp, 16'hFFFF);
    exp_exit(16'h0ABC, 16'h8011, 16'h0001);
    step(1'b0, 1'b1, n);
    chk("R9 wrapped return sp", core_sp, 16'h0001);
    chk("R9 wrapped return pc", core_pc, 16'h0ABC);

    chk("R8 R9 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule